// File: doc/BRIEF.md
# Memory Fence Release Tracker

This block sits inside a load/store unit and keeps a small in-order queue of outstanding memory fences. Each fence carries a four-bit ordering mask that says which kinds of earlier accesses it must wait for and which kinds of later accesses it holds back. A second flag marks a fence as strict: no speculative load or prefetch may move past it.

Two outstanding-operation counters are kept, one for loads and one for stores. Each counter goes up when an access of its kind issues and down when one completes. Every cycle, each queued fence latches whether the counters it depends on have been seen at zero since it was allocated. The oldest fence retires once all of its dependencies have drained.

From the queue state the block gives the issue logic an early signal for the cycle. It says whether later loads and later stores are currently held by ordering, and whether speculation may pass every queued fence. It also raises a strobe in the cycle a fence retires, so that completed speculative loads waiting behind that fence can leave the unit.

Top module: `fence_release_tracker`

## Requirements
- R1: After reset no fence is queued (`fence_valid` all zero), `ld_blocked`, `st_blocked` and `spec_release` are low, and `spec_pass_ok` equals `spec_en`.
- R2: Mask bit 0 means load-to-load, bit 1 load-to-store, bit 2 store-to-load and bit 3 store-to-store ordering. `ld_blocked` is high while any queued fence has bit 0 or bit 2 set. `st_blocked` is high while any queued fence has bit 1 or bit 3 set.
- R3: A fence waits on the load counter when mask bit 0 or 1 is set, and on the store counter when bit 2 or 3 is set. It never retires while a counter it waits on has stayed nonzero since its allocation, and a counter it does not wait on has no effect on it.
- R4: A fence retires at the second clock edge after the edge on which the last counter it waits on is zero, counting the allocation edge if that counter is already zero.
- R5: Fences retire strictly in allocation order, at most one per cycle, and `fence_valid` is packed from bit 0 (oldest) upward.
- R6: At most FENCES fences are queued. An allocation arriving while the queue is full and nothing retires is ignored.
- R7: `spec_release` is high exactly in the cycle before a fence's retiring edge, and only while `spec_en` is high.
- R8: `spec_pass_ok` is high when `spec_en` is high and no queued fence has its strict flag set.
- R9: A fence allocated on the same edge as a retirement is not evaluated in the following cycle: it cannot retire earlier than R4 allows.
- R10: A load or store issuing in the same cycle as one of its kind completes leaves that counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a new fence this cycle |
| alloc_mask | input | 4 | Ordering mask of the new fence |
| alloc_strict | input | 1 | New fence forbids speculation and prefetch past it |
| op_issue | input | 2 | Access issued this cycle, bit 0 load, bit 1 store |
| op_done | input | 2 | Access completed this cycle, bit 0 load, bit 1 store |
| spec_en | input | 1 | Speculative load execution enabled |
| fence_valid | output | FENCES | Queue occupancy, bit 0 oldest |
| ld_blocked | output | 1 | Later loads held by ordering |
| st_blocked | output | 1 | Later ready stores held by ordering |
| spec_pass_ok | output | 1 | Speculative loads and prefetches may pass all queued fences |
| spec_release | output | 1 | A fence retires at the coming edge; waiting speculative loads may leave |

## Verification
The bench uses the default of four fence slots and a four-bit counter width. With those values the queue can be filled and overfilled in a handful of cycles. A full queue can then be drained one entry per edge after a single load completes, which exposes the in-order retirement and the behaviour of allocation while full. The small counters keep the outstanding-load and outstanding-store cases short. They still leave room for a simultaneous issue and completion on a nonzero count.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int KINDS  = 2;
  localparam int MASK_W = 4;

  typedef struct packed {
    logic              valid;
    logic              strict;
    logic [MASK_W-1:0] mask;
    logic [KINDS-1:0]  drained;
  } fence_t;

  // which counters a fence depends on: bit0 loads, bit1 stores
  function automatic logic [KINDS-1:0] waits_on(input logic [MASK_W-1:0] m);
    return {m[3] | m[2], m[1] | m[0]};
  endfunction

  function automatic logic holds_loads(input logic [MASK_W-1:0] m);
    return m[0] | m[2];
  endfunction

  function automatic logic holds_stores(input logic [MASK_W-1:0] m);
    return m[1] | m[3];
  endfunction

  function automatic logic [7:0] count_step(input logic [7:0] c, input logic up, input logic dn);
    logic [7:0] r;
    r = c;
    if (up && !dn) r = c + 8'd1;
    else if (dn && !up) r = c - 8'd1;
    return r;
  endfunction
endpackage

// File: rtl/frt_kind_counter.sv
module frt_kind_counter #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic done,
  output logic is_zero
);
  import frt_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       step_w;

  assign step_w  = count_step(8'(cnt_q), issue, done);
  assign is_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= step_w[CNT_W-1:0];
  end

  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !issue) |-> (cnt_q != '0));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !done) |-> (cnt_q != {CNT_W{1'b1}}));

  assert_pair_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && done) |=> $stable(cnt_q));
endmodule

// File: rtl/frt_fence_queue.sv
module frt_fence_queue #(
  parameter int FENCES = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                alloc_valid,
  input  logic [frt_pkg::MASK_W-1:0]          alloc_mask,
  input  logic                                alloc_strict,
  input  logic [frt_pkg::KINDS-1:0]           kind_zero,
  output logic [FENCES-1:0]                   ent_valid,
  output logic [FENCES-1:0]                   ent_strict,
  output logic [FENCES-1:0][frt_pkg::MASK_W-1:0] ent_mask,
  output logic                                retire
);
  import frt_pkg::*;

  localparam int CW = $clog2(FENCES + 1);

  fence_t        q_r   [FENCES];
  fence_t        upd_w [FENCES];
  fence_t        nxt_w [FENCES];
  logic [CW-1:0] occ_q;
  logic [CW-1:0] wp_w;
  logic          accept;

  // oldest entry is releasable once every counter it waits on has drained
  assign retire = q_r[0].valid &&
                  ((waits_on(q_r[0].mask) & ~q_r[0].drained) == '0);
  assign accept = alloc_valid && ((occ_q < CW'(FENCES)) || retire);
  assign wp_w   = retire ? occ_q - CW'(1) : occ_q;

  always_comb begin
    for (int i = 0; i < FENCES; i++) begin
      upd_w[i] = q_r[i];
      if (q_r[i].valid) upd_w[i].drained = q_r[i].drained | kind_zero;
    end
    for (int i = 0; i < FENCES; i++) begin
      if (retire) nxt_w[i] = (i < FENCES - 1) ? upd_w[(i + 1) % FENCES] : '0;
      else        nxt_w[i] = upd_w[i];
      if (accept && (CW'(i) == wp_w)) begin
        nxt_w[i].valid   = 1'b1;
        nxt_w[i].strict  = alloc_strict;
        nxt_w[i].mask    = alloc_mask;
        nxt_w[i].drained = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q <= '0;
      for (int i = 0; i < FENCES; i++) q_r[i] <= '0;
    end else begin
      occ_q <= occ_q + CW'(accept) - CW'(retire);
      for (int i = 0; i < FENCES; i++) q_r[i] <= nxt_w[i];
    end
  end

  generate
    for (genvar g = 0; g < FENCES; g++) begin : g_out
      assign ent_valid[g]  = q_r[g].valid;
      assign ent_strict[g] = q_r[g].strict;
      assign ent_mask[g]   = q_r[g].mask;
    end
  endgenerate

  assert_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= CW'(FENCES));

  assert_pop_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !accept) |=> (occ_q == $past(occ_q) - CW'(1)));

  assert_top_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !accept) |=> !ent_valid[FENCES-1]);

  assert_packed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ent_valid) == int'(occ_q));
endmodule

// File: rtl/fence_release_tracker.sv
module fence_release_tracker #(
  parameter int FENCES = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [3:0]        alloc_mask,
  input  logic              alloc_strict,
  input  logic [1:0]        op_issue,
  input  logic [1:0]        op_done,
  input  logic              spec_en,
  output logic [FENCES-1:0] fence_valid,
  output logic              ld_blocked,
  output logic              st_blocked,
  output logic              spec_pass_ok,
  output logic              spec_release
);
  import frt_pkg::*;

  logic [KINDS-1:0]               kind_zero;
  logic [FENCES-1:0]              ent_strict;
  logic [FENCES-1:0][MASK_W-1:0]  ent_mask;
  logic                           retire;
  logic [FENCES-1:0]              hold_ld_w;
  logic [FENCES-1:0]              hold_st_w;

  generate
    for (genvar k = 0; k < KINDS; k++) begin : g_cnt
      frt_kind_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (op_issue[k]),
        .done    (op_done[k]),
        .is_zero (kind_zero[k])
      );
    end
    for (genvar g = 0; g < FENCES; g++) begin : g_hold
      assign hold_ld_w[g] = fence_valid[g] && holds_loads(ent_mask[g]);
      assign hold_st_w[g] = fence_valid[g] && holds_stores(ent_mask[g]);
    end
  endgenerate

  frt_fence_queue #(.FENCES(FENCES)) queue_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_mask   (alloc_mask),
    .alloc_strict (alloc_strict),
    .kind_zero    (kind_zero),
    .ent_valid    (fence_valid),
    .ent_strict   (ent_strict),
    .ent_mask     (ent_mask),
    .retire       (retire)
  );

  assign ld_blocked   = |hold_ld_w;
  assign st_blocked   = |hold_st_w;
  assign spec_pass_ok = spec_en && !(|(fence_valid & ent_strict));
  assign spec_release = spec_en && retire;

  assert_release_has_fence_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spec_release |-> fence_valid[0]);

  assert_strict_stops_spec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_valid[0] && ent_strict[0] && !retire) |=> !spec_pass_ok);
endmodule

// File: tb/fence_release_tracker_tb_top.sv
module fence_release_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       alloc_valid;
  logic [3:0] alloc_mask;
  logic       alloc_strict;
  logic [1:0] op_issue;
  logic [1:0] op_done;
  logic       spec_en;
  logic [3:0] fence_valid;
  logic       ld_blocked, st_blocked, spec_pass_ok, spec_release;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fence_release_tracker #(.FENCES(4), .CNT_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_mask(alloc_mask),
    .alloc_strict(alloc_strict), .op_issue(op_issue), .op_done(op_done), .spec_en(spec_en),
    .fence_valid(fence_valid), .ld_blocked(ld_blocked), .st_blocked(st_blocked),
    .spec_pass_ok(spec_pass_ok), .spec_release(spec_release)
  );

  task automatic tick();
    @(posedge clk); #1;
    alloc_valid = 1'b0; op_issue = '0; op_done = '0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; alloc_valid = 0; alloc_mask = 0; alloc_strict = 0;
    op_issue = 0; op_done = 0; spec_en = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic fence(input logic [3:0] m, input logic s);
    alloc_valid = 1'b1; alloc_mask = m; alloc_strict = s;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 valid", fence_valid, 0);
    chk("R1 ldblk", ld_blocked, 0);
    chk("R1 stblk", st_blocked, 0);
    chk("R1 rel", spec_release, 0);
    chk("R1 pass", spec_pass_ok, 1);
  endtask

  task automatic t_quick();
    fence(4'b0001, 0);
    chk("R2 ld held", ld_blocked, 1);
    chk("R2 st free", st_blocked, 0);
    chk("R4 no early rel", spec_release, 0);
    tick();
    chk("R7 rel strobe", spec_release, 1);
    chk("R4 still queued", fence_valid, 4'b0001);
    tick();
    chk("R4 retired", fence_valid, 0);
    chk("R7 rel low", spec_release, 0);
  endtask

  task automatic t_wait_load();
    op_issue = 2'b01; tick();
    fence(4'b0010, 0);
    chk("R2 st held", st_blocked, 1);
    chk("R2 ld free", ld_blocked, 0);
    repeat (5) tick();
    chk("R3 waits load", fence_valid, 4'b0001);
    op_issue = 2'b01; op_done = 2'b01; tick();
    repeat (3) tick();
    chk("R10 pair keeps count", fence_valid, 4'b0001);
    op_done = 2'b01; tick();
    tick();
    chk("R4 rel after drain", spec_release, 1);
    tick();
    chk("R4 gone", fence_valid, 0);
  endtask

  task automatic t_other_kind();
    op_issue = 2'b01; tick();
    fence(4'b1000, 0);
    tick();
    chk("R3 ignores loads", spec_release, 1);
    tick();
    chk("R3 retired", fence_valid, 0);
    op_done = 2'b01; tick();
  endtask

  task automatic t_strict();
    op_issue = 2'b10; tick();
    fence(4'b0100, 0);
    chk("R8 plain fence", spec_pass_ok, 1);
    fence(4'b0100, 1);
    chk("R8 strict fence", spec_pass_ok, 0);
    spec_en = 1'b0; #1;
    chk("R8 spec off", spec_pass_ok, 0);
    op_done = 2'b10; tick();
    tick();
    chk("R7 no rel when off", spec_release, 0);
    chk("R5 head first", fence_valid, 4'b0011);
    tick();
    chk("R5 one per cycle", fence_valid, 4'b0001);
    tick();
    chk("R5 drained", fence_valid, 0);
    spec_en = 1'b1; #1;
    chk("R8 restored", spec_pass_ok, 1);
  endtask

  task automatic t_full();
    op_issue = 2'b01; tick();
    for (int i = 0; i < 4; i++) fence(4'b0001, 0);
    chk("R6 full", fence_valid, 4'b1111);
    fence(4'b0010, 1);
    chk("R6 ignored", fence_valid, 4'b1111);
    chk("R6 no strict taken", spec_pass_ok, 1);
    chk("R6 st free", st_blocked, 0);
    op_done = 2'b01; tick();
    tick();
    chk("R5 full stays", fence_valid, 4'b1111);
    tick(); chk("R5 pop1", fence_valid, 4'b0111);
    tick(); chk("R5 pop2", fence_valid, 4'b0011);
    tick(); chk("R5 pop3", fence_valid, 4'b0001);
    tick(); chk("R5 pop4", fence_valid, 4'b0000);
  endtask

  task automatic t_same_cycle();
    fence(4'b0001, 0);
    tick();
    chk("R9 head releasing", spec_release, 1);
    fence(4'b0100, 0);
    chk("R9 new one only", fence_valid, 4'b0001);
    chk("R9 new not evaluated", spec_release, 0);
    chk("R9 mask of new", st_blocked, 0);
    tick();
    chk("R9 then releases", spec_release, 1);
    tick();
    chk("R9 cleared", fence_valid, 0);
  endtask

  initial begin
    do_reset();
    #1;
    t_reset();
    t_quick();
    t_wait_load();
    t_other_kind();
    t_strict();
    t_full();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule